// File: doc/BRIEF.md
# Frame-Timed Toggling Watchdog

This block is a watchdog timer whose output is wired to the reset pin of a microcontroller. It measures time only in frame periods. A frame pulse arrives at 8 kHz, and its falling edges are the block's only time reference. The interval is a fixed 512 ms, which is 4096 frame periods. Firmware keeps the output low by writing a fixed service pattern to one register address more often than once per interval.

An external power-on reset forces the output high. When that reset is released, the output drops at once and the first interval begins. If firmware misses an interval, or writes the wrong pattern, nothing happens until the running interval ends. At that point the output goes high. It then toggles once per interval, and keeps doing so until a correct service write arrives. That write drives it low and starts a fresh interval.

A service write is captured into a flag in the system clock domain. The flag acts on the next frame falling edge. A write that coincides with an expiry edge therefore takes effect one edge later, in the following interval.

Top module: `wdog_toggle`

## Requirements
- R1: While `por_i` is high, `wd_o` is high, whatever the frame and write inputs do.
- R2: When `por_i` falls, `wd_o` goes low combinationally and the interval count starts at zero. The first expiry is the TICKS-th frame falling edge after release (TICKS = 4096 by default).
- R3: The interval count advances only on a falling edge of `frame_i`. A falling edge is a clock where `frame_i` is 0 and it was 1 in the previous clock. Idle clocks and rising edges leave `wd_o` and the count unchanged.
- R4: A correct service is a write with `wr_addr_i` = 0x11 and `wr_data_i[4:0]` = 5'b01010, with every higher data bit ignored. At the next frame falling edge it clears the count to zero and drives `wd_o` low.
- R5: A write to 0x11 whose low five bits differ from 01010 neither restarts the count nor changes `wd_o`. The output trips when the running interval ends.
- R6: A write to any address other than 0x11 has no effect on the watchdog.
- R7: Without a correct service, `wd_o` inverts on the TICKS-th falling edge after the last restart or inversion. The first inversion takes it high, and it keeps toggling every TICKS edges after that.
- R8: A correct service received while `wd_o` is toggling drives `wd_o` low at the next falling edge. The next expiry then comes TICKS edges later.
- R9: A correct service write in the same clock as an expiry edge does not cancel that expiry, which still inverts `wd_o`. The service takes effect at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register samples on its rising edge |
| por_i | input | 1 | Asynchronous power-on reset, active high |
| frame_i | input | 1 | 8 kHz frame pulse, synchronous to `clk`; its falling edge is the time base |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data; only bits 4:0 are compared |
| wd_o | output | 1 | Watchdog output to the microcontroller reset line |

## Verification
A count that is off by even one edge moves the first transition of `wd_o` by a whole frame period. So the bench samples the output on the edge just before each predicted expiry and on the expiry edge itself. A service flag that is lost, or one that sticks, shows up one edge after the write. Either the output fails to drop, or the next expiry arrives early or late. A wrongly accepted pattern or address shows only when the running interval ends: the output then stays low when it should have gone high. For that reason the bad-write scenarios run the interval out in full.

// File: rtl/wdog_toggle.sv
module wdog_toggle #(
  parameter int FRAME_HZ   = 8000,
  parameter int TIMEOUT_MS = 512,
  parameter int TICKS      = FRAME_HZ * TIMEOUT_MS / 1000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h11,
  parameter logic [4:0]        SVC_WORD = 5'b01010
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              frame_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wd_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          frame_q;
  logic          pending;
  logic          wd_q;
  logic [CW-1:0] cnt;
  logic          fall;
  logic          svc_ok;
  logic          expire;

  assign fall   = frame_q & ~frame_i;
  assign svc_ok = wr_en_i && (wr_addr_i == SVC_ADDR) && (wr_data_i[4:0] == SVC_WORD);
  assign expire = (cnt == LAST);
  assign wd_o   = por_i | wd_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      frame_q <= 1'b0;
      pending <= 1'b0;
      wd_q    <= 1'b0;
      cnt     <= '0;
    end else begin
      frame_q <= frame_i;
      pending <= svc_ok | (pending & ~fall);
      if (fall) begin
        if (pending) begin
          cnt  <= '0;
          wd_q <= 1'b0;
        end else if (expire) begin
          cnt  <= '0;
          wd_q <= ~wd_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_toggle_chk.sv
module wdog_toggle_chk #(
  parameter int TICKS  = 4096,
  parameter int CW     = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h11,
  parameter logic [4:0]        SVC_WORD = 5'b01010
) (
  input logic              clk,
  input logic              por_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wd_o,
  input logic              wd_q,
  input logic              fall,
  input logic              pending,
  input logic [CW-1:0]     cnt
);
  a_r1_por_high: assert property (@(posedge clk) por_i |-> wd_o);

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (por_i)
    int'(cnt) < TICKS);

  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (por_i)
    !fall |=> ($stable(wd_q) && $stable(cnt)));

  a_r4_service_restarts: assert property (@(posedge clk) disable iff (por_i)
    (fall && pending) |=> (cnt == '0 && !wd_o));

  a_r5_bad_word_ignored: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && wr_addr_i == SVC_ADDR && wr_data_i[4:0] != SVC_WORD && !pending)
      |=> !pending);

  a_r6_foreign_addr_ignored: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && wr_addr_i != SVC_ADDR && !pending) |=> !pending);

  a_r7_toggle_on_expiry: assert property (@(posedge clk) disable iff (por_i)
    (fall && !pending && int'(cnt) == TICKS - 1) |=> (wd_q != $past(wd_q)));
endmodule

bind wdog_toggle wdog_toggle_chk #(
  .TICKS(TICKS), .CW(CW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SVC_ADDR(SVC_ADDR), .SVC_WORD(SVC_WORD)
) chk_i (
  .clk(clk), .por_i(por_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wd_o(wd_o), .wd_q(wd_q), .fall(fall),
  .pending(pending), .cnt(cnt)
);

// File: tb/wdog_toggle_tb_top.sv
module wdog_toggle_tb_top;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       frame_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       wd_o;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wdog_toggle #(.TICKS(T)) dut_i (
    .clk(clk), .por_i(por_i), .frame_i(frame_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wd_o(wd_o)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (wd_o !== exp) begin
      fails++;
      $display("FAIL %s: wd_o=%b expected %b at %0t", req, wd_o, exp, $time);
    end
  endtask

  // One frame: pulse high, then low; returns one negedge after the fall is taken.
  task automatic frame_fall(input logic with_wr = 1'b0, input logic [7:0] d = 8'h0A);
    @(negedge clk) frame_i = 1'b1;
    repeat (3) @(negedge clk);
    frame_i = 1'b0;
    if (with_wr) begin
      wr_en_i = 1'b1; wr_addr_i = 8'h11; wr_data_i = d;
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) frame_fall();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic restore();
    wr(8'h11, 8'h0A);
    frame_fall();
    chk("R4", 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", 1'b1);
    falls(3);
    wr(8'h11, 8'h0A);
    chk("R1", 1'b1);
    @(negedge clk);
    por_i = 1'b0;
    #1 chk("R2", 1'b0);
  endtask

  task automatic t_first_expiry();
    falls(T - 1);
    chk("R2", 1'b0);
    falls(1);
    chk("R7", 1'b1);
  endtask

  task automatic t_toggle();
    falls(T - 1);
    chk("R7", 1'b1);
    falls(1);
    chk("R7", 1'b0);
    falls(T);
    chk("R7", 1'b1);
  endtask

  task automatic t_service_toggling();
    wr(8'h11, 8'hEA);
    chk("R4", 1'b1);
    frame_fall();
    chk("R8", 1'b0);
    falls(T - 1);
    chk("R8", 1'b0);
    falls(1);
    chk("R8", 1'b1);
  endtask

  task automatic t_keepalive();
    restore();
    for (int k = 0; k < 5; k++) begin
      falls(T - 6);
      wr(8'h11, 8'hEA);
      frame_fall();
    end
    chk("R4", 1'b0);
  endtask

  task automatic t_wrong_data();
    restore();
    falls(8);
    wr(8'h11, 8'h0B);
    chk("R5", 1'b0);
    falls(T - 9);
    chk("R5", 1'b0);
    falls(1);
    chk("R5", 1'b1);
  endtask

  task automatic t_other_addr();
    restore();
    falls(8);
    wr(8'h12, 8'h0A);
    falls(T - 9);
    chk("R6", 1'b0);
    falls(1);
    chk("R6", 1'b1);
  endtask

  task automatic t_idle();
    restore();
    repeat (200) @(negedge clk);
    chk("R3", 1'b0);
    frame_i = 1'b1;
    repeat (150) @(negedge clk);
    frame_i = 1'b0;
    @(negedge clk);
    chk("R3", 1'b0);
    falls(T - 2);
    chk("R3", 1'b0);
    falls(1);
    chk("R3", 1'b1);
  endtask

  task automatic t_edge_write();
    restore();
    falls(T - 1);
    chk("R9", 1'b0);
    frame_fall(1'b1, 8'h2A);
    chk("R9", 1'b1);
    frame_fall();
    chk("R9", 1'b0);
    falls(T - 1);
    chk("R9", 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        t_reset();
        t_first_expiry();
        t_toggle();
        t_service_toggling();
        t_keepalive();
        t_wrong_data();
        t_other_addr();
        t_idle();
        t_edge_write();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule